// File: doc/BRIEF.md
# Horizontal Drive Start/Stop Guard

This block decides when the horizontal output stage receives drive pulses. After reset the drive stays low. A strobe that reports that every control register has been loaded starts an oscillator calibration request. When calibration reports a correct frequency, the drive comes up through a soft start. In that phase the pulse train runs at twice the line rate with a short, safe high time. After a fixed number of these pulses the block switches to line-rate pulses with a half-period duty cycle.

Several inputs take the drive down again, each in its own way. A detected power-on reset brings the drive down through a soft stop. After that, only the full register-load and calibration sequence restarts it. Loss of line lock sends the block back to calibration. An over-voltage detect either causes a soft stop or only raises a status flag, depending on a mode input. A second protection input cuts the drive in the same cycle, and when it clears the drive restarts through soft start. The flyback window always blanks the pulse. All pulse timing comes from an internal reference counter clocked by the system clock.

Top module: `hdrv_guard`

## Requirements
- R1: While reset is asserted, and afterwards until a register-load strobe is accepted, `hDrive`, `calReq` and `protFlag` are low.
- R2: `regStrobe` is accepted only in the idle (off) state and only when `porDetect` is low. `calReq` is high from the next cycle. A strobe in any other state has no effect.
- R3: While `calReq` is high, `calDone` starts a soft start whose first pulse begins in the next cycle. The soft start runs `SOFT_PULSES` pulses of period `LINE_PERIOD/2`, each high for its first `SOFT_ON` cycles. Normal run follows at once, with period `LINE_PERIOD`, high for the first `LINE_PERIOD/2` cycles. `calDone` has no effect outside calibration.
- R4: `porDetect` during soft start or run starts a soft stop in the next cycle: `SOFT_PULSES` double-rate pulses with the soft high time, then the off state. `porDetect` during calibration returns the block directly to off. From off, a new `regStrobe` and `calDone` are needed to restart.
- R5: Loss of `inLock` during soft start or run returns the block to calibration in the next cycle: `calReq` goes high and `hDrive` stays low.
- R6: When `overVolt` is high during soft start or run and `stopOnOv` is 1, a soft stop follows, then the off state. With `stopOnOv` at 0 the drive keeps its pulse train unchanged.
- R7: `protFlag` equals the value `overVolt` had one cycle earlier, in every state and mode.
- R8: `protTrip` forces `hDrive` low in the same cycle, in every state. During soft start or run it holds the block in a tripped state. When it clears, a soft start begins from its first pulse. During a soft stop it ends the stop and the block goes to off.
- R9: `flyback` forces `hDrive` low in the same cycle and does not change the sequence or the pulse timing.
- R10: When several events occur in the same cycle during soft start or run, the priority is power-on reset, then protection trip, then over-voltage stop, then lock loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timebase for pulse generation |
| rstN | input | 1 | Asynchronous active-low reset |
| regStrobe | input | 1 | One-cycle strobe: all control registers have been loaded |
| calDone | input | 1 | Calibration reports a correct oscillator frequency |
| inLock | input | 1 | Line oscillator is locked to incoming sync |
| porDetect | input | 1 | A supply dip or power-on reset has been detected |
| overVolt | input | 1 | Over-voltage detect |
| protTrip | input | 1 | Second protection input; cuts the drive immediately |
| stopOnOv | input | 1 | 1: over-voltage causes a soft stop; 0: flag only |
| flyback | input | 1 | Flyback window; the drive is blanked while high |
| hDrive | output | 1 | Horizontal drive pulse |
| calReq | output | 1 | Request to run oscillator calibration |
| protFlag | output | 1 | Over-voltage status, delayed one cycle |

## Verification
The hardest coincidence is a power-on reset and a protection trip in the same cycle during run. The power-on reset must select the soft stop, while the trip must still blank the drive combinationally. The trip, still held, must then end the soft stop and leave the block in off, with no soft start when the trip releases. The bench raises both inputs on one clock edge. A behavioural model tracks the sequence by elapsed cycles and compares drive and request on every cycle. A second coincidence, a trip together with an over-voltage stop request, must resolve to the tripped state and then to a fresh soft start.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_CAL    = 3'd1,
    ST_SOFTUP = 3'd2,
    ST_RUN    = 3'd3,
    ST_SOFTDN = 3'd4,
    ST_TRIP   = 3'd5
  } hdrvState_e;

  typedef enum logic [1:0] {
    SHAPE_NONE = 2'd0,
    SHAPE_SOFT = 2'd1,
    SHAPE_FULL = 2'd2
  } pulseShape_e;

  // Strobes from the sequencer to the timebase datapath
  typedef struct packed {
    logic        restart;  // clear phase and pulse counters
    logic        advance;  // step the phase counter
    pulseShape_e shape;    // which waveform to form
  } tbStrobe_t;

endpackage

// File: rtl/hdrv_timebase.sv
module hdrv_timebase
  import hdrv_pkg::*;
#(
  parameter int unsigned LINE_PERIOD = 64,
  parameter int unsigned SOFT_ON     = 8,
  parameter int unsigned SOFT_PULSES = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  tbStrobe_t stb,
  input  logic      flyback,
  input  logic      protTrip,
  output logic      softDone,
  output logic      hDrive
);

  localparam int unsigned HALF = LINE_PERIOD / 2;
  localparam int unsigned PW   = $clog2(LINE_PERIOD);
  localparam int unsigned CW   = $clog2(SOFT_PULSES + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(LINE_PERIOD - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(HALF);
  localparam logic [PW-1:0] PH_MID  = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_ON   = PW'(SOFT_ON);
  localparam logic [CW-1:0] CNT_TOP = CW'(SOFT_PULSES - 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(SOFT_PULSES);

  logic [PW-1:0] phase;
  logic [CW-1:0] halfCount;
  logic          halfEnd;
  logic [PW-1:0] halfPos;
  logic          rawPulse;

  assign halfEnd  = (phase == PH_MID) || (phase == PH_LAST);
  assign softDone = halfEnd && (halfCount == CNT_TOP);
  assign halfPos  = (phase >= PH_HALF) ? (phase - PH_HALF) : phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      halfCount <= '0;
    end else if (stb.restart) begin
      phase     <= '0;
      halfCount <= '0;
    end else if (stb.advance) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (halfEnd && (halfCount != CNT_SAT)) halfCount <= halfCount + 1'b1;
    end
  end

  always_comb begin
    case (stb.shape)
      SHAPE_SOFT: rawPulse = (halfPos < PH_ON);
      SHAPE_FULL: rawPulse = (phase < PH_HALF);
      default:    rawPulse = 1'b0;
    endcase
  end

  assign hDrive = rawPulse && !flyback && !protTrip;

endmodule

// File: rtl/hdrv_ctrl.sv
module hdrv_ctrl
  import hdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regStrobe,
  input  logic       calDone,
  input  logic       inLock,
  input  logic       porDetect,
  input  logic       overVolt,
  input  logic       protTrip,
  input  logic       stopOnOv,
  input  logic       softDone,
  output tbStrobe_t  stb,
  output logic       calReq,
  output logic       protFlag,
  output hdrvState_e curState
);

  hdrvState_e nxtState;
  logic       counting;

  always_comb begin
    nxtState = curState;
    case (curState)
      ST_OFF: if (regStrobe && !porDetect) nxtState = ST_CAL;
      ST_CAL: begin
        if (porDetect)    nxtState = ST_OFF;
        else if (calDone) nxtState = ST_SOFTUP;
      end
      ST_SOFTUP, ST_RUN: begin
        if (porDetect)                 nxtState = ST_SOFTDN;
        else if (protTrip)             nxtState = ST_TRIP;
        else if (overVolt && stopOnOv) nxtState = ST_SOFTDN;
        else if (!inLock)              nxtState = ST_CAL;
        else if ((curState == ST_SOFTUP) && softDone) nxtState = ST_RUN;
      end
      ST_SOFTDN: if (protTrip || softDone) nxtState = ST_OFF;
      ST_TRIP: begin
        if (porDetect)     nxtState = ST_OFF;
        else if (!protTrip) nxtState = ST_SOFTUP;
      end
      default: nxtState = ST_OFF;
    endcase
  end

  assign counting = (curState == ST_SOFTUP) || (curState == ST_RUN) ||
                    (curState == ST_SOFTDN);

  always_comb begin
    stb.restart = !counting || (nxtState != curState);
    stb.advance = counting && (nxtState == curState);
    case (curState)
      ST_SOFTUP, ST_SOFTDN: stb.shape = SHAPE_SOFT;
      ST_RUN:               stb.shape = SHAPE_FULL;
      default:              stb.shape = SHAPE_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_OFF;
      protFlag <= 1'b0;
    end else begin
      curState <= nxtState;
      protFlag <= overVolt;
    end
  end

  assign calReq = (curState == ST_CAL);

endmodule

// File: rtl/hdrv_guard.sv
module hdrv_guard
  import hdrv_pkg::*;
#(
  parameter int unsigned LINE_PERIOD = 64,
  parameter int unsigned SOFT_ON     = 8,
  parameter int unsigned SOFT_PULSES = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic regStrobe,
  input  logic calDone,
  input  logic inLock,
  input  logic porDetect,
  input  logic overVolt,
  input  logic protTrip,
  input  logic stopOnOv,
  input  logic flyback,
  output logic hDrive,
  output logic calReq,
  output logic protFlag
);

  tbStrobe_t  tbStb;
  logic       softDone;
  hdrvState_e curState;

  hdrv_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regStrobe (regStrobe),
    .calDone   (calDone),
    .inLock    (inLock),
    .porDetect (porDetect),
    .overVolt  (overVolt),
    .protTrip  (protTrip),
    .stopOnOv  (stopOnOv),
    .softDone  (softDone),
    .stb       (tbStb),
    .calReq    (calReq),
    .protFlag  (protFlag),
    .curState  (curState)
  );

  hdrv_timebase #(
    .LINE_PERIOD (LINE_PERIOD),
    .SOFT_ON     (SOFT_ON),
    .SOFT_PULSES (SOFT_PULSES)
  ) u_timebase (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (tbStb),
    .flyback  (flyback),
    .protTrip (protTrip),
    .softDone (softDone),
    .hDrive   (hDrive)
  );

endmodule

// File: rtl/hdrv_guard_chk.sv
module hdrv_guard_chk
  import hdrv_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       flyback,
  input logic       protTrip,
  input logic       porDetect,
  input logic       overVolt,
  input logic       stopOnOv,
  input logic       inLock,
  input logic       hDrive,
  input logic       calReq,
  input hdrvState_e st
);

  // R9
  fly_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    flyback |-> !hDrive);

  // R8
  trip_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    protTrip |-> !hDrive);

  // R5
  cal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    calReq |-> !hDrive);

  // R4
  por_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && porDetect) |=> (st == ST_SOFTDN));

  // R6
  ov_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RUN && overVolt && !stopOnOv && inLock && !protTrip && !porDetect)
      |=> (st == ST_RUN));

endmodule

bind hdrv_guard hdrv_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flyback   (flyback),
  .protTrip  (protTrip),
  .porDetect (porDetect),
  .overVolt  (overVolt),
  .stopOnOv  (stopOnOv),
  .inLock    (inLock),
  .hDrive    (hDrive),
  .calReq    (calReq),
  .st        (curState)
);

// File: tb/hdrv_guard_bench.sv
`timescale 1ns/1ps
module hdrv_guard_bench;

  localparam int P    = 64;
  localparam int SON  = 8;
  localparam int NS   = 6;
  localparam int HALF = P / 2;

  localparam int M_OFF = 0, M_CAL = 1, M_UP = 2, M_RUN = 3, M_DN = 4, M_TRIP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regStrobe = 1'b0, calDone = 1'b0, inLock = 1'b1, porDetect = 1'b0;
  logic overVolt = 1'b0, protTrip = 1'b0, stopOnOv = 1'b0, flyback = 1'b0;
  logic hDrive, calReq, protFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference model state
  int mState = M_OFF;
  int mTime = 0;
  bit mFlag = 0;

  always #10 clk = ~clk;

  hdrv_guard #(.LINE_PERIOD(P), .SOFT_ON(SON), .SOFT_PULSES(NS)) u_hdrv_guard (
    .clk(clk), .rstN(rstN), .regStrobe(regStrobe), .calDone(calDone),
    .inLock(inLock), .porDetect(porDetect), .overVolt(overVolt),
    .protTrip(protTrip), .stopOnOv(stopOnOv), .flyback(flyback),
    .hDrive(hDrive), .calReq(calReq), .protFlag(protFlag)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mState = M_OFF; mTime = 0; mFlag = 0;
    end else begin
      mFlag = overVolt;
      case (mState)
        M_OFF: if (regStrobe && !porDetect) begin mState = M_CAL; mTime = 0; end
        M_CAL: begin
          if (porDetect) mState = M_OFF;
          else if (calDone) begin mState = M_UP; mTime = 0; end
        end
        M_UP, M_RUN: begin
          if (porDetect) begin mState = M_DN; mTime = 0; end
          else if (protTrip) begin mState = M_TRIP; mTime = 0; end
          else if (overVolt && stopOnOv) begin mState = M_DN; mTime = 0; end
          else if (!inLock) begin mState = M_CAL; mTime = 0; end
          else if (mState == M_UP && mTime + 1 == NS * HALF) begin mState = M_RUN; mTime = 0; end
          else if (mState == M_RUN) mTime = (mTime + 1) % P;
          else mTime = mTime + 1;
        end
        M_DN: begin
          if (protTrip || mTime + 1 == NS * HALF) begin mState = M_OFF; mTime = 0; end
          else mTime = mTime + 1;
        end
        M_TRIP: begin
          if (porDetect) mState = M_OFF;
          else if (!protTrip) begin mState = M_UP; mTime = 0; end
        end
        default: mState = M_OFF;
      endcase
    end
  end

  function automatic bit expDrive();
    bit p;
    p = 0;
    if (mState == M_UP || mState == M_DN) p = (mTime % HALF) < SON;
    else if (mState == M_RUN) p = mTime < HALF;
    return p && !flyback && !protTrip;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (hDrive !== expDrive() || calReq !== (mState == M_CAL) || protFlag !== mFlag) begin
        bad++;
        $display("FAIL %s cycle compare: drive/req/flag act=%b%b%b exp=%b%b%b at %0t",
                 tag, hDrive, calReq, protFlag, expDrive(), (mState == M_CAL), mFlag, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic countHigh(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); if (hDrive) hi++; end
  endtask

  task automatic bringUp();
    regStrobe = 1; tick(1); regStrobe = 0;
    tick(3);
    calDone = 1; tick(1); calDone = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish();
  end

  initial begin
    int hi;
    // R1: reset state
    tag = "R1";
    tick(4);
    check(hDrive == 0, "R1", "drive in reset", hDrive, 0);
    check(calReq == 0, "R1", "calReq in reset", calReq, 0);
    check(protFlag == 0, "R1", "flag in reset", protFlag, 0);
    rstN = 1; tick(10);
    calDone = 1; tick(1); calDone = 0; tick(2);   // R3: calDone ignored when off
    check(calReq == 0, "R3", "calDone outside calibration", calReq, 0);
    countHigh(P, hi); tick(1);
    check(hi == 0, "R1", "idle drive cycles", hi, 0);

    // R2: strobe accepted in off
    tag = "R2";
    regStrobe = 1; tick(1); regStrobe = 0;
    check(calReq == 1, "R2", "calReq after strobe", calReq, 1);
    regStrobe = 1; tick(1); regStrobe = 0;  // ignored during calibration
    tick(3);

    // R3: soft start then run
    tag = "R3";
    calDone = 1; tick(1); calDone = 0;
    countHigh(NS * HALF, hi);
    check(hi == NS * SON, "R3", "soft start high cycles", hi, NS * SON);
    countHigh(P, hi);
    check(hi == HALF, "R3", "run high cycles per line", hi, HALF);
    tick(1);

    // R9: flyback blanks without disturbing timing
    tag = "R9";
    flyback = 1; countHigh(P, hi); tick(1);
    check(hi == 0, "R9", "drive under flyback", hi, 0);
    flyback = 0; countHigh(P, hi); tick(1);
    check(hi == HALF, "R9", "drive after flyback", hi, HALF);

    // R6 / R7: flag-only mode keeps drive running
    tag = "R6";
    stopOnOv = 0; overVolt = 1; tick(2);
    check(protFlag == 1, "R7", "flag follows over-voltage", protFlag, 1);
    countHigh(P, hi); tick(1);
    check(hi == HALF, "R6", "drive in flag-only mode", hi, HALF);
    overVolt = 0; tick(2);
    check(protFlag == 0, "R7", "flag clears", protFlag, 0);

    // R5: lock loss re-runs calibration
    tag = "R5";
    inLock = 0; tick(1); inLock = 1;
    check(calReq == 1, "R5", "calReq after lock loss", calReq, 1);
    countHigh(8, hi); tick(1);
    check(hi == 0, "R5", "drive during recalibration", hi, 0);
    calDone = 1; tick(1); calDone = 0;

    // R8: trip during soft start, then restart from first pulse
    tag = "R8";
    tick(20);
    protTrip = 1; countHigh(20, hi); tick(1);
    check(hi == 0, "R8", "drive while tripped", hi, 0);
    protTrip = 0; tick(1);
    countHigh(NS * HALF, hi);
    check(hi == NS * SON, "R8", "soft start after trip", hi, NS * SON);
    tick(P);

    // R6: stop mode gives soft stop then off
    tag = "R6";
    stopOnOv = 1; overVolt = 1; tick(1); overVolt = 0;
    countHigh(NS * HALF, hi);
    check(hi == NS * SON, "R6", "soft stop high cycles", hi, NS * SON);
    countHigh(P, hi); tick(1);
    check(hi == 0 && calReq == 0, "R6", "off after soft stop", hi, 0);

    // R4: power-on reset in run, strobe during stop ignored
    tag = "R4";
    bringUp(); tick(NS * HALF + 10);
    porDetect = 1; tick(1); porDetect = 0;
    tick(5);
    regStrobe = 1; tick(1); regStrobe = 0;   // R2: ignored during soft stop
    tick(NS * HALF);
    check(calReq == 0, "R2", "strobe during soft stop", calReq, 0);
    countHigh(P, hi); tick(1);
    check(hi == 0, "R4", "off after power-on reset", hi, 0);
    regStrobe = 1; tick(1); regStrobe = 0;
    porDetect = 1; tick(1); porDetect = 0;
    check(calReq == 0, "R4", "por during calibration", calReq, 0);

    // R10: por together with trip during run
    tag = "R10";
    bringUp(); tick(NS * HALF + 10);
    porDetect = 1; protTrip = 1; tick(1); porDetect = 0;
    countHigh(10, hi); tick(1);
    check(hi == 0, "R10", "drive with por and trip", hi, 0);
    protTrip = 0; countHigh(P, hi); tick(1);
    check(hi == 0 && calReq == 0, "R10", "off after por+trip", hi, 0);

    // R10: trip wins over over-voltage stop
    bringUp(); tick(NS * HALF + 10);
    stopOnOv = 1; overVolt = 1; protTrip = 1; tick(1); overVolt = 0;
    tick(4); protTrip = 0; tick(1);
    countHigh(NS * HALF, hi);
    check(hi == NS * SON, "R10", "soft start after trip over ov", hi, NS * SON);
    countHigh(P, hi); tick(1);
    check(hi == HALF, "R10", "run after trip over ov", hi, HALF);

    tick(5);
    finish();
  end

endmodule